// File: doc/BRIEF.md
# XOR-Coded Contention Recovery Output Stage

This block is one output port of a speculative switch. It assumes no collision, so a lone requesting input has its flit put on the output link in the same cycle it asks. When several inputs ask together, the cycle is still used. The link carries the bitwise XOR of every competing flit. A round-robin arbiter picks one winner and grants it, and that winner is dropped from the competing set. On each following cycle the stage sends the XOR of the inputs that remain and drops one more winner. The run ends on the cycle when a single flit goes out alone. A run of k colliding flits therefore takes exactly k back-to-back link cycles, the same as k uncontended transfers.

A receiver-side decoder is included. It holds the previous coded word in a one-entry buffer, together with a flag that marks the word that closed a run. It recovers each flit by XORing that buffered word with the word that follows it, or by passing the buffered word through unchanged when it was the last word of a run. Flits come out one cycle after their coded word, in the order the arbiter granted them. Requests that arrive while a run is in progress wait until the run is over.

Top module: `xor_recovery_output`

## Requirements
- R1: With exactly one request at the start of a run, the same cycle shows encValid=1, encLast=1, encData equal to that input's data, and a grant to that input.
- R2: With two or more requests at the start of a run, encData equals the bitwise XOR of all requesting inputs' data, and encLast=0.
- R3: Whenever encValid=1, exactly one grant bit is high. When encValid=0, no grant bit is high.
- R4: After each cycle, the granted input is removed from the set. The next cycle carries the XOR of the remaining members. The run continues every cycle, and encLast=1 marks the cycle in which one member remains.
- R5: The winner is the first member of the set found at or after the priority pointer, searching upward with wrap-around. After each grant the pointer moves to winner+1 modulo the input count. Reset sets the pointer to input 0.
- R6: A request raised during a run is neither granted nor included in encData until that run has ended.
- R7: One cycle after each coded word, decValid=1 and decData equals the flit that was granted in that word's cycle. decValid=0 one cycle after a cycle with encValid=0.
- R8: While reset is asserted, encValid=0 and no grant is given, whatever the requests. The cycle after reset shows decValid=0.
- R9: With no request and no run in progress, encValid=0 and all grants are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_IN | Per-input request, held until granted |
| dataIn | input | NUM_IN*DATA_W | Per-input flit, input i at bits [i*DATA_W +: DATA_W] |
| grantOut | output | NUM_IN | One-hot grant for the current cycle |
| encValid | output | 1 | Coded word present on the link |
| encData | output | DATA_W | Coded word (XOR of the current competing set) |
| encLast | output | 1 | Current word holds a single flit and closes the run |
| decValid | output | 1 | Decoded flit valid |
| decData | output | DATA_W | Decoded flit |

## Verification
In the same cycle, the decoder emits the previous run's final flit by passing its buffered word through, while the encoder starts a new run or sits idle. The decoder also combines a mid-run buffered word with a live coded word while the arbiter removes the next winner. The sweep runs every nonempty set of four requesters back to back, at several pointer positions, with one idle cycle between runs. In some passes, extra requests are raised in the middle of a run. Each cycle, the bench computes from its own model the expected coded word, grant, run-end flag and decoded flit, and compares them with the outputs.

// File: rtl/xor_recovery_pkg.sv
package xor_recovery_pkg;
  localparam int MAX_IN = 16;

  typedef struct packed {
    logic [MAX_IN-1:0] selMask;
    logic              wordValid;
    logic              wordLast;
  } ctrlStrobe_t;
endpackage

// File: rtl/xor_recovery_ctrl.sv
module xor_recovery_ctrl
  import xor_recovery_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] reqIn,
  output logic [NUM_IN-1:0] grantOut,
  output ctrlStrobe_t       strobe
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic              inRun;
  logic [NUM_IN-1:0] liveSet;
  logic [IDX_W-1:0]  prioPtr;
  logic [NUM_IN-1:0] compSet;
  logic [IDX_W-1:0]  winIdx;
  logic              winFound;
  logic              lastOne;

  always_comb begin
    compSet = '0;
    if (rstN) compSet = inRun ? liveSet : reqIn;
  end

  always_comb begin
    winIdx   = '0;
    winFound = 1'b0;
    for (int j = 0; j < NUM_IN; j++) begin
      int idx;
      idx = (int'(prioPtr) + j) % NUM_IN;
      if (!winFound && compSet[idx]) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(idx);
      end
    end
  end

  assign lastOne  = ($countones(compSet) == 1);
  assign grantOut = winFound ? (NUM_IN'(1) << winIdx) : '0;

  always_comb begin
    strobe           = '0;
    strobe.selMask   = MAX_IN'(compSet);
    strobe.wordValid = winFound;
    strobe.wordLast  = winFound && lastOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inRun   <= 1'b0;
      liveSet <= '0;
      prioPtr <= '0;
    end else if (winFound) begin
      liveSet <= compSet & ~grantOut;
      inRun   <= !lastOne;
      prioPtr <= (int'(winIdx) == NUM_IN - 1) ? '0 : winIdx + 1'b1;
    end
  end
endmodule

// File: rtl/xor_recovery_datapath.sv
module xor_recovery_datapath
  import xor_recovery_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN*DATA_W-1:0] dataIn,
  input  ctrlStrobe_t              strobe,
  output logic [DATA_W-1:0]        encData,
  output logic                     decValid,
  output logic [DATA_W-1:0]        decData
);
  logic [DATA_W-1:0] codedBuf;
  logic              bufValid;
  logic              bufLast;

  always_comb begin
    encData = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (strobe.selMask[i]) encData = encData ^ dataIn[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codedBuf <= '0;
      bufValid <= 1'b0;
      bufLast  <= 1'b0;
    end else begin
      bufValid <= strobe.wordValid;
      bufLast  <= strobe.wordLast;
      if (strobe.wordValid) codedBuf <= encData;
    end
  end

  assign decValid = bufValid;
  assign decData  = bufLast ? codedBuf : (codedBuf ^ encData);
endmodule

// File: rtl/xor_recovery_output.sv
module xor_recovery_output
  import xor_recovery_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        reqIn,
  input  logic [NUM_IN*DATA_W-1:0] dataIn,
  output logic [NUM_IN-1:0]        grantOut,
  output logic                     encValid,
  output logic [DATA_W-1:0]        encData,
  output logic                     encLast,
  output logic                     decValid,
  output logic [DATA_W-1:0]        decData
);
  ctrlStrobe_t strobe;

  xor_recovery_ctrl #(.NUM_IN(NUM_IN)) ctrlInst (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .grantOut(grantOut), .strobe(strobe)
  );

  xor_recovery_datapath #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) dpInst (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .encData(encData), .decValid(decValid), .decData(decData)
  );

  assign encValid = strobe.wordValid;
  assign encLast  = strobe.wordLast;
endmodule

// File: rtl/xor_recovery_checker.sv
module xor_recovery_checker #(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] reqIn,
  input logic [NUM_IN-1:0] grantOut,
  input logic              encValid,
  input logic              encLast,
  input logic              decValid
);
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid |-> $countones(grantOut) == 1);

  // R3
  no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    !encValid |-> grantOut == '0);

  // R4
  run_continues_chk: assert property (@(posedge clk) disable iff (!rstN)
    (encValid && !encLast) |=> encValid);

  // R4
  winner_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (encValid && !encLast) |=> (grantOut & $past(grantOut)) == '0);

  // R1
  lone_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!$past(encValid) || $past(encLast)) && $countones(reqIn) == 1)
      |-> (encValid && encLast && grantOut == reqIn));

  // R7
  decode_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> decValid);

  // R7
  decode_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !encValid |=> !decValid);
endmodule

bind xor_recovery_output xor_recovery_checker #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) chkInst (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .grantOut(grantOut),
  .encValid(encValid), .encLast(encLast), .decValid(decValid)
);

// File: tb/xor_recovery_output_test.sv
`timescale 1ns/1ps
module xor_recovery_output_test;
  localparam int N = 4;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rstN;
  logic [N-1:0]   reqIn;
  logic [N*W-1:0] dataIn;
  logic [N-1:0]   grantOut;
  logic           encValid, encLast, decValid;
  logic [W-1:0]   encData, decData;

  int checkCnt = 0;
  int failCnt  = 0;
  int modelPtr = 0;
  bit prevValid = 0;
  logic [W-1:0] prevData = '0;
  logic [W-1:0] flit [N];

  always #2.5 clk = ~clk;

  xor_recovery_output #(.NUM_IN(N), .DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .dataIn(dataIn), .grantOut(grantOut),
    .encValid(encValid), .encData(encData), .encLast(encLast),
    .decValid(decValid), .decData(decData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkDecoder();
    chk(decValid == prevValid, "R7 decValid", 32'(decValid), 32'(prevValid));
    if (prevValid) chk(decData == prevData, "R7 decData", 32'(decData), 32'(prevData));
  endtask

  task automatic runSet(input logic [N-1:0] members, input bit inject);
    logic [N-1:0] live;
    logic [N-1:0] req;
    bit first;
    live  = members;
    req   = members;
    first = 1;
    for (int i = 0; i < N; i++) begin
      flit[i] = W'($urandom);
      dataIn[i*W +: W] = flit[i];
    end
    reqIn = req;
    while (live != '0) begin
      logic [W-1:0] expXor;
      int win;
      bit isLast;
      @(negedge clk);
      expXor = '0;
      for (int i = 0; i < N; i++) if (live[i]) expXor ^= flit[i];
      win = -1;
      for (int j = 0; j < N; j++) begin
        int idx;
        idx = (modelPtr + j) % N;
        if (win < 0 && live[idx]) win = idx;
      end
      isLast = ($countones(live) == 1);
      chk(encValid == 1'b1, "R4 encValid in run", 32'(encValid), 32'd1);
      if (first && isLast) chk(encData == expXor, "R1 lone flit", 32'(encData), 32'(expXor));
      else if (first)      chk(encData == expXor, "R2 full xor", 32'(encData), 32'(expXor));
      else                 chk(encData == expXor, "R4 R6 remaining xor", 32'(encData), 32'(expXor));
      chk(grantOut == N'(1 << win), "R5 R3 grant", 32'(grantOut), 32'(1 << win));
      chk(encLast == isLast, "R4 encLast", 32'(encLast), 32'(isLast));
      checkDecoder();
      prevValid = 1;
      prevData  = flit[win];
      live[win] = 1'b0;
      modelPtr  = (win + 1) % N;
      @(posedge clk); #1;
      req[win] = 1'b0;
      if (inject && first && live != '0) req = req | (~members);
      if (live == '0) req = '0;
      reqIn = req;
      first = 0;
    end
    @(negedge clk);
    chk(encValid == 1'b0, "R9 idle valid", 32'(encValid), 32'd0);
    chk(grantOut == '0, "R9 idle grant", 32'(grantOut), 32'd0);
    checkDecoder();
    prevValid = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    rstN   = 1'b0;
    reqIn  = '1;
    dataIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(encValid == 1'b0, "R8 reset valid", 32'(encValid), 32'd0);
    chk(grantOut == '0, "R8 reset grant", 32'(grantOut), 32'd0);
    @(posedge clk); #1;
    rstN  = 1'b1;
    reqIn = '0;
    @(negedge clk);
    chk(decValid == 1'b0, "R8 decValid after reset", 32'(decValid), 32'd0);
    chk(encValid == 1'b0, "R9 no request", 32'(encValid), 32'd0);
    @(posedge clk); #1;
    for (int rep = 0; rep < 6; rep++) begin
      for (int s = 1; s < (1 << N); s++) begin
        runSet(N'(s), rep[0]);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule